// File: doc/BRIEF.md
# Snooping DMA Coherence Responder

This block sits beside one write-back cache and watches the shared memory bus for transfers started by other masters, such as a DMA engine. Each snooped transfer gives a line address and a direction. The block looks the line up through a dedicated snoop read port on a small tag and state array, so the processor-side port stays free for lookups and fills in the same cycle.

Each accepted snoop produces exactly one action code one cycle later.
- A foreign read of a line held modified makes the cache intervene. The block raises a supply request and a bus-inhibit signal, so memory's stale copy is not used, and holds both until the data mover acknowledges. The line is left clean.
- A foreign write that hits the line drops the local copy, whether the line was clean or modified. A modified line is not written back, because the incoming write replaces the whole line.
- Every other case, including any miss, needs no action.

Top module: `snoop_coherence_responder`

## Requirements
- R1: After reset every entry reads as invalid (state 2'b00), act_valid is 0 and supply_req and bus_inhibit are 0.
- R2: An accepted snoop produces act_valid one cycle later. A snoop that misses (the entry is invalid or its tag differs) gives act_code 2'b00, meaning no action.
- R3: A foreign read (snp_write=0) of a line held clean (state 2'b01) gives act_code 2'b00 and leaves the line clean with its tag.
- R4: A foreign read of a line held modified (state 2'b11) gives act_code 2'b01, meaning intervene. In the same cycle as act_valid it raises supply_req and bus_inhibit, with supply_addr equal to the snooped line address, and the line becomes clean (2'b01).
- R5: A foreign write (snp_write=1) of a line held clean gives act_code 2'b10, meaning purge, and the entry becomes invalid.
- R6: A foreign write of a line held modified gives act_code 2'b10. The entry becomes invalid and no supply request is raised.
- R7: A foreign write that misses gives act_code 2'b00 and leaves the indexed entry's tag and state unchanged.
- R8: supply_req and bus_inhibit stay asserted, with supply_addr stable, until supply_ack is sampled high. They are low from the following cycle.
- R9: When a processor write and a snoop state update target the same entry in the same cycle, the snoop update wins. A processor write that collides with a snoop taking no action lands normally.
- R10: A snoop presented while a supply request is pending is ignored. It produces no action and changes no entry.
- R11: The processor read port returns the tag and state of the entry at cpu_idx in the same cycle, independent of snoop activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr | input | 1 | Processor write of one entry |
| cpu_idx | input | IDX_W | Processor entry index (read and write) |
| cpu_tag | input | TAG_W | Tag to write |
| cpu_st | input | 2 | State to write: 00 invalid, 01 clean, 11 modified |
| cpu_rd_tag | output | TAG_W | Tag of entry cpu_idx |
| cpu_rd_st | output | 2 | State of entry cpu_idx |
| snp_valid | input | 1 | Foreign transfer observed on the bus |
| snp_write | input | 1 | 1 = foreign write, 0 = foreign read |
| snp_line | input | TAG_W+IDX_W | Line address {tag, index} |
| act_valid | output | 1 | Action result valid |
| act_code | output | 2 | 00 none, 01 intervene, 10 purge |
| supply_req | output | 1 | Request to move dirty line onto the bus |
| supply_addr | output | TAG_W+IDX_W | Line to supply |
| supply_ack | input | 1 | Data moved; ends the request |
| bus_inhibit | output | 1 | Stops memory answering while the cache intervenes |

## Verification
The hardest situations to reach are two. The first is a snoop that arrives while an intervention is still waiting for its acknowledge. The second is a processor write landing on the very entry a snoop is changing in the same cycle. The stimulus reaches the first by leaving supply_ack low for several cycles after an intervene and issuing a would-be purge in that window. The absence of any action and the unchanged entry are then confirmed through the processor read port. For the collision, the stimulus drives cpu_wr and snp_valid in one cycle on the same index. It does this once where the snoop purges and once where the snoop misses, so both directions of the priority rule are exercised.

// File: rtl/snoop_coherence_responder.sv
module snoop_coherence_responder #(
  parameter int TAG_W = 11,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_wr,
  input  logic [IDX_W-1:0]       cpu_idx,
  input  logic [TAG_W-1:0]       cpu_tag,
  input  logic [1:0]             cpu_st,
  output logic [TAG_W-1:0]       cpu_rd_tag,
  output logic [1:0]             cpu_rd_st,
  input  logic                   snp_valid,
  input  logic                   snp_write,
  input  logic [TAG_W+IDX_W-1:0] snp_line,
  output logic                   act_valid,
  output logic [1:0]             act_code,
  output logic                   supply_req,
  output logic [TAG_W+IDX_W-1:0] supply_addr,
  input  logic                   supply_ack,
  output logic                   bus_inhibit
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [1:0] ACT_NONE = 2'b00;
  localparam logic [1:0] ACT_IVN  = 2'b01;
  localparam logic [1:0] ACT_PRG  = 2'b10;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [1:0]       st_q  [ENTRIES];

  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic s_go, s_hit, do_ivn, do_purge, s_upd;

  assign s_idx    = snp_line[IDX_W-1:0];
  assign s_tag    = snp_line[TAG_W+IDX_W-1:IDX_W];
  assign s_go     = snp_valid && !supply_req;
  assign s_hit    = st_q[s_idx][0] && (tag_q[s_idx] == s_tag);
  assign do_ivn   = s_go && !snp_write && s_hit && st_q[s_idx][1];
  assign do_purge = s_go && snp_write && s_hit;
  assign s_upd    = do_ivn || do_purge;

  assign cpu_rd_tag  = tag_q[cpu_idx];
  assign cpu_rd_st   = st_q[cpu_idx];
  assign bus_inhibit = supply_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= 2'b00;
      end
    end else begin
      if (cpu_wr && !(s_upd && cpu_idx == s_idx)) begin
        tag_q[cpu_idx] <= cpu_tag;
        st_q[cpu_idx]  <= cpu_st;
      end
      if (do_purge)    st_q[s_idx] <= 2'b00;
      else if (do_ivn) st_q[s_idx] <= 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid   <= 1'b0;
      act_code    <= ACT_NONE;
      supply_req  <= 1'b0;
      supply_addr <= '0;
    end else begin
      act_valid <= s_go;
      act_code  <= do_ivn ? ACT_IVN : (do_purge ? ACT_PRG : ACT_NONE);
      if (do_ivn) begin
        supply_req  <= 1'b1;
        supply_addr <= snp_line;
      end else if (supply_ack) begin
        supply_req <= 1'b0;
      end
    end
  end

  assert_result_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_go |=> act_valid);
  assert_ivn_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_code == ACT_IVN |-> supply_req && bus_inhibit);
  assert_purge_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_code == ACT_PRG |-> !$rose(supply_req));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_req && !supply_ack |=> supply_req && $stable(supply_addr));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_req && supply_ack |=> !supply_req);
  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && supply_req |=> !act_valid);
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> act_code != 2'b11);
endmodule

// File: tb/snoop_coherence_responder_tb.sv
module snoop_coherence_responder_tb;
  localparam int TAG_W = 11;
  localparam int IDX_W = 3;
  localparam int LW = TAG_W + IDX_W;

  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0;
  logic [IDX_W-1:0] cpu_idx = '0;
  logic [TAG_W-1:0] cpu_tag = '0;
  logic [1:0] cpu_st = '0;
  logic [TAG_W-1:0] cpu_rd_tag;
  logic [1:0] cpu_rd_st;
  logic snp_valid = 0, snp_write = 0;
  logic [LW-1:0] snp_line = '0;
  logic act_valid;
  logic [1:0] act_code;
  logic supply_req, bus_inhibit, supply_ack = 0;
  logic [LW-1:0] supply_addr;

  int checks = 0, errors = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  snoop_coherence_responder #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
    .cpu_st(cpu_st), .cpu_rd_tag(cpu_rd_tag), .cpu_rd_st(cpu_rd_st),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_line(snp_line),
    .act_valid(act_valid), .act_code(act_code), .supply_req(supply_req),
    .supply_addr(supply_addr), .supply_ack(supply_ack), .bus_inhibit(bus_inhibit));

  function automatic logic [LW-1:0] mk(input int t, input int i);
    return {t[TAG_W-1:0], i[IDX_W-1:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && act_valid) begin
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R10 unexpected action actual=%0h expected=none", act_code);
    end else begin
      logic [1:0] e;
      string r;
      e = exp_q.pop_front();
      r = tag_q.pop_front();
      chk(r, act_code, e);
    end
  end

  task automatic fill(input int i, input int t, input logic [1:0] st);
    cpu_wr = 1; cpu_idx = i[IDX_W-1:0]; cpu_tag = t[TAG_W-1:0]; cpu_st = st;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic snoop(input logic wr, input logic [LW-1:0] ln, input logic [1:0] e, input string r);
    snp_valid = 1; snp_write = wr; snp_line = ln;
    exp_q.push_back(e); tag_q.push_back(r);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic peek(input string r, input int i, input int t, input logic [1:0] st);
    cpu_idx = i[IDX_W-1:0];
    #1;
    chk(r, cpu_rd_st, st);
    if (st != 2'b00) chk(r, cpu_rd_tag, t[TAG_W-1:0]);
  endtask

  initial begin
    #80000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", act_valid, 0);
    chk("R1", bus_inhibit, 0);
    for (int i = 0; i < (1 << IDX_W); i++) peek("R1", i, 0, 2'b00);
    rst_n = 1;
    @(negedge clk);
    // R2 read miss
    snoop(0, mk(5, 1), 2'b00, "R2");
    // R3 read clean hit
    fill(1, 5, 2'b01);
    snoop(0, mk(5, 1), 2'b00, "R3");
    peek("R3", 1, 5, 2'b01);
    // R4 read modified hit
    fill(2, 7, 2'b11);
    snoop(0, mk(7, 2), 2'b01, "R4");
    chk("R4", supply_req, 1);
    chk("R4", bus_inhibit, 1);
    chk("R4", supply_addr, mk(7, 2));
    peek("R4", 2, 7, 2'b01);
    repeat (3) @(negedge clk);
    chk("R8", supply_req, 1);
    chk("R8", supply_addr, mk(7, 2));
    // R10 snoop while pending is ignored
    snp_valid = 1; snp_write = 1; snp_line = mk(5, 1);
    @(negedge clk);
    snp_valid = 0;
    @(negedge clk);
    peek("R10", 1, 5, 2'b01);
    chk("R10", supply_req, 1);
    supply_ack = 1;
    @(negedge clk);
    supply_ack = 0;
    chk("R8", supply_req, 0);
    chk("R8", bus_inhibit, 0);
    // R5 write clean hit
    snoop(1, mk(5, 1), 2'b10, "R5");
    peek("R5", 1, 5, 2'b00);
    // R6 write modified hit
    fill(3, 9, 2'b11);
    snoop(1, mk(9, 3), 2'b10, "R6");
    chk("R6", supply_req, 0);
    peek("R6", 3, 9, 2'b00);
    // R7 write miss, R11 read port during snoop
    fill(4, 2, 2'b01);
    cpu_idx = 4;
    snp_valid = 1; snp_write = 1; snp_line = mk(3, 4);
    exp_q.push_back(2'b00); tag_q.push_back("R7");
    #1;
    chk("R11", cpu_rd_tag, 2);
    chk("R11", cpu_rd_st, 2'b01);
    @(negedge clk);
    snp_valid = 0;
    peek("R7", 4, 2, 2'b01);
    // R9 collision where snoop purges
    fill(5, 1, 2'b01);
    cpu_wr = 1; cpu_idx = 5; cpu_tag = 1; cpu_st = 2'b11;
    snoop(1, mk(1, 5), 2'b10, "R9");
    cpu_wr = 0;
    peek("R9", 5, 1, 2'b00);
    // R9 collision where snoop misses
    cpu_wr = 1; cpu_idx = 5; cpu_tag = 6; cpu_st = 2'b01;
    snoop(1, mk(6, 5), 2'b00, "R9");
    cpu_wr = 0;
    peek("R9", 5, 6, 2'b01);
    repeat (2) @(negedge clk);
    chk("R2", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule